// File: doc/BRIEF.md
# Per-Service Flow Hash Server Selector

This block sits behind a packet header parser in a layer-4 balancing data path. For every packet it takes the IPv4 source and destination addresses and the two transport ports. It then decides whether the destination is one of the virtual service addresses that have been programmed. When the destination matches, the four fields are folded into a five-bit hash. The hash is placed inside a window of a shared backend table that belongs to the matched service, and the selected entry gives the real server address. Because the mapping depends only on the four fields and the programmed tables, every packet of one session reaches the same backend.

A processor programs three kinds of state through a write-only register port: the backend table entries, one virtual address per service, and a per-service word. That word holds the service's window base, its window size as a power of two, and an enable bit. Lookups run through a two-stage pipeline with a valid/ready handshake on both sides. The result carries a hit flag, the winning service number and the server address. A miss returns zeros and a cleared hit flag, so downstream logic forwards the packet unchanged.

Top module: `vipFlowSelector`

## Requirements
- R1: While reset is held and right after it, `outValid` is 0, `inReady` is 1, and `outHit`, `outSvc` and `outServer` are 0.
- R2: A lookup whose destination equals the address of an enabled service returns `outHit`=1 and that service's number in `outSvc`. A disabled service never matches.
- R3: A lookup that matches no enabled service returns `outHit`=0, `outSvc`=0 and `outServer`=0.
- R4: When several enabled services hold the same address, the lowest-numbered one wins.
- R5: The tuple is the 96-bit word {source IP [95:64], destination IP [63:32], source port [31:16], destination port [15:0]}. Hash bit j (0..4) is the XOR of every tuple bit k with k mod 5 = j.
- R6: On a hit, the table entry read is (base + (hash AND (2^size − 1))) mod 32, where base and size come from the matched service. A size above 5 acts as 5.
- R7: Repeating an identical tuple while the configuration is unchanged always yields the same server address.
- R8: With `outReady` held high, a result appears exactly 2 cycles after the input handshake, and one lookup per cycle is sustained.
- R9: While `outValid`=1 and `outReady`=0, the result holds steady. Results leave in acceptance order, with none lost or repeated.
- R10: A table entry or service address write made while a result waits at the output leaves that result unchanged. Lookups accepted after the write use the new value.
- R11: The register map is set by `cfgAddr`. Bit 5 = 0 writes table entry `cfgAddr[4:0]`. Bits [5:4] = 10 write the address of service `cfgAddr[2:0]`. Bits [5:4] = 11 write that service's word, with base in data[4:0], size in data[10:8] and enable in data[31].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Lookup request valid |
| inReady | output | 1 | Selector can accept a lookup |
| inSrcIp | input | 32 | IPv4 source address |
| inDstIp | input | 32 | IPv4 destination address |
| inSrcPort | input | 16 | Transport source port |
| inDstPort | input | 16 | Transport destination port |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 6 | Register write address |
| cfgWrData | input | 32 | Register write data |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Downstream accepts the result |
| outHit | output | 1 | Destination matched an enabled service |
| outSvc | output | 3 | Matched service number (0 on a miss) |
| outServer | output | 32 | Selected backend address (0 on a miss) |

## Verification
The assertions assume that the downstream side obeys the handshake. In particular, the design relies on `outReady` alone to release a held result, and it needs no stability from `inValid` beyond a single sampled edge. The bench therefore drives `outReady` and the request fields only just after a rising edge, and it raises `cfgWrEn` for exactly one cycle per write. Configuration writes that change a mapping are issued only while the pipeline is idle, or while a single result is parked under backpressure. This keeps the bench's model of the table in step with what each in-flight lookup reads.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  localparam int IP_W         = 32;
  localparam int PORT_W       = 16;
  localparam int CFG_SIZE_LSB = 8;
  localparam int CFG_EN_BIT   = 31;

  typedef enum logic [1:0] {
    SPACE_NONE = 2'd0,
    SPACE_RING = 2'd1,
    SPACE_VIP  = 2'd2,
    SPACE_SVC  = 2'd3
  } regSpace_e;

  typedef struct packed {
    logic s1Load;
    logic s2Load;
    logic ringWe;
    logic vipWe;
    logic svcCfgWe;
  } vfsStrobes_t;
endpackage

// File: rtl/vfsHashFold.sv
module vfsHashFold #(
  parameter int IN_W  = 96,
  parameter int OUT_W = 5
) (
  input  logic [IN_W-1:0]  tuple,
  output logic [OUT_W-1:0] hash
);
  localparam int SLICES = (IN_W + OUT_W - 1) / OUT_W;
  localparam int PAD_W  = SLICES * OUT_W;

  logic [PAD_W-1:0] padded;
  logic [OUT_W-1:0] acc [SLICES+1];

  assign padded = PAD_W'(tuple);
  assign acc[0] = '0;

  // each slice lands bit k on position k mod OUT_W
  for (genvar g = 0; g < SLICES; g++) begin : g_fold
    assign acc[g+1] = acc[g] ^ padded[g*OUT_W +: OUT_W];
  end

  assign hash = acc[SLICES];
endmodule

// File: rtl/vfsVipMatch.sv
module vfsVipMatch #(
  parameter int NUM_SVC = 8,
  parameter int IP_W    = 32,
  localparam int SVC_W  = $clog2(NUM_SVC)
) (
  input  logic [IP_W-1:0]         dstIp,
  input  logic [NUM_SVC*IP_W-1:0] vipFlat,
  input  logic [NUM_SVC-1:0]      svcEn,
  output logic                    hit,
  output logic [SVC_W-1:0]        svcIdx
);
  logic [NUM_SVC-1:0] eqVec;

  for (genvar g = 0; g < NUM_SVC; g++) begin : g_cmp
    assign eqVec[g] = svcEn[g] && (vipFlat[g*IP_W +: IP_W] == dstIp);
  end

  // lowest matching service wins
  always_comb begin
    hit    = |eqVec;
    svcIdx = '0;
    for (int i = NUM_SVC - 1; i >= 0; i--) begin
      if (eqVec[i]) svcIdx = SVC_W'(i);
    end
  end
endmodule

// File: rtl/vfsCtrl.sv
module vfsCtrl
  import vfs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              outReady,
  output logic              outValid,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  output vfsStrobes_t       strobes
);
  logic      s1ValidQ;
  logic      outValidQ;
  logic      s2Free;
  logic      s1Move;
  logic      accept;
  regSpace_e space;

  assign s2Free  = !outValidQ || outReady;
  assign s1Move  = s1ValidQ && s2Free;
  assign inReady = !s1ValidQ || s2Free;
  assign accept  = inValid && inReady;
  assign outValid = outValidQ;

  always_comb begin
    if (!cfgWrEn)                   space = SPACE_NONE;
    else if (!cfgAddr[ADDR_W-1])    space = SPACE_RING;
    else if (!cfgAddr[ADDR_W-2])    space = SPACE_VIP;
    else                            space = SPACE_SVC;
  end

  always_comb begin
    strobes          = '0;
    strobes.s1Load   = accept;
    strobes.s2Load   = s1Move;
    strobes.ringWe   = (space == SPACE_RING);
    strobes.vipWe    = (space == SPACE_VIP);
    strobes.svcCfgWe = (space == SPACE_SVC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1ValidQ  <= 1'b0;
      outValidQ <= 1'b0;
    end else begin
      if (accept)      s1ValidQ <= 1'b1;
      else if (s1Move) s1ValidQ <= 1'b0;

      if (s1Move)        outValidQ <= 1'b1;
      else if (outReady) outValidQ <= 1'b0;
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValidQ && !outReady |=> outValidQ);

  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !s1ValidQ |-> inReady);

  // R8
  advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    s1ValidQ && outReady |=> outValidQ);
endmodule

// File: rtl/vfsDatapath.sv
module vfsDatapath
  import vfs_pkg::*;
#(
  parameter int NUM_SVC      = 8,
  parameter int RING_ENTRIES = 32,
  parameter int ADDR_W       = 6,
  localparam int SVC_W       = $clog2(NUM_SVC),
  localparam int RING_IDX_W  = $clog2(RING_ENTRIES),
  localparam int SIZE_W      = $clog2(RING_IDX_W + 1),
  localparam int TUPLE_W     = 2 * IP_W + 2 * PORT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  vfsStrobes_t       strobes,
  input  logic [IP_W-1:0]   inSrcIp,
  input  logic [IP_W-1:0]   inDstIp,
  input  logic [PORT_W-1:0] inSrcPort,
  input  logic [PORT_W-1:0] inDstPort,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [IP_W-1:0]   cfgWrData,
  output logic              outHit,
  output logic [SVC_W-1:0]  outSvc,
  output logic [IP_W-1:0]   outServer
);
  logic [IP_W-1:0]       vipReg   [NUM_SVC];
  logic [NUM_SVC-1:0]    svcEn;
  logic [RING_IDX_W-1:0] svcBase  [NUM_SVC];
  logic [SIZE_W-1:0]     svcSize  [NUM_SVC];
  logic [IP_W-1:0]       ringMem  [RING_ENTRIES];

  logic [NUM_SVC*IP_W-1:0] vipFlat;
  logic                    matchHit;
  logic [SVC_W-1:0]        matchIdx;
  logic [RING_IDX_W-1:0]   hashComb;

  logic                  s1Hit;
  logic [SVC_W-1:0]      s1Svc;
  logic [RING_IDX_W-1:0] s1Hash;

  logic [SIZE_W-1:0]     sizeClamp;
  logic [RING_IDX_W:0]   windowSpan;
  logic [RING_IDX_W-1:0] windowMask;
  logic [RING_IDX_W-1:0] ringIdx;

  logic [SVC_W-1:0]      cfgSvc;
  logic [RING_IDX_W-1:0] cfgRing;

  assign cfgSvc  = cfgAddr[SVC_W-1:0];
  assign cfgRing = cfgAddr[RING_IDX_W-1:0];

  // ---------------- configuration storage ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcEn <= '0;
      for (int i = 0; i < NUM_SVC; i++) begin
        vipReg[i]  <= '0;
        svcBase[i] <= '0;
        svcSize[i] <= '0;
      end
    end else begin
      if (strobes.vipWe) vipReg[cfgSvc] <= cfgWrData;
      if (strobes.svcCfgWe) begin
        svcBase[cfgSvc] <= cfgWrData[RING_IDX_W-1:0];
        svcSize[cfgSvc] <= cfgWrData[CFG_SIZE_LSB +: SIZE_W];
        svcEn[cfgSvc]   <= cfgWrData[CFG_EN_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RING_ENTRIES; i++) ringMem[i] <= '0;
    end else if (strobes.ringWe) begin
      ringMem[cfgRing] <= cfgWrData;
    end
  end

  for (genvar g = 0; g < NUM_SVC; g++) begin : g_flat
    assign vipFlat[g*IP_W +: IP_W] = vipReg[g];
  end

  // ---------------- stage 1: match and hash ----------------
  vfsVipMatch #(
    .NUM_SVC (NUM_SVC),
    .IP_W    (IP_W)
  ) match_i (
    .dstIp   (inDstIp),
    .vipFlat (vipFlat),
    .svcEn   (svcEn),
    .hit     (matchHit),
    .svcIdx  (matchIdx)
  );

  vfsHashFold #(
    .IN_W  (TUPLE_W),
    .OUT_W (RING_IDX_W)
  ) hash_i (
    .tuple ({inSrcIp, inDstIp, inSrcPort, inDstPort}),
    .hash  (hashComb)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Hit  <= 1'b0;
      s1Svc  <= '0;
      s1Hash <= '0;
    end else if (strobes.s1Load) begin
      s1Hit  <= matchHit;
      s1Svc  <= matchIdx;
      s1Hash <= hashComb;
    end
  end

  // ---------------- stage 2: window and table read ----------------
  always_comb begin
    if (svcSize[s1Svc] > SIZE_W'(RING_IDX_W)) sizeClamp = SIZE_W'(RING_IDX_W);
    else                                      sizeClamp = svcSize[s1Svc];
    windowSpan = (RING_IDX_W+1)'(1) << sizeClamp;
    windowMask = RING_IDX_W'(windowSpan - (RING_IDX_W+1)'(1));
    ringIdx    = svcBase[s1Svc] + (s1Hash & windowMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outHit    <= 1'b0;
      outSvc    <= '0;
      outServer <= '0;
    end else if (strobes.s2Load) begin
      outHit    <= s1Hit;
      outSvc    <= s1Hit ? s1Svc : '0;
      outServer <= s1Hit ? ringMem[ringIdx] : '0;
    end
  end

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outHit |-> (outServer == '0) && (outSvc == '0));

  // R10
  result_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.s2Load |=> $stable(outServer) && $stable(outHit) && $stable(outSvc));
endmodule

// File: rtl/vipFlowSelector.sv
module vipFlowSelector
  import vfs_pkg::*;
#(
  parameter int NUM_SVC      = 8,
  parameter int RING_ENTRIES = 32,
  localparam int SVC_W       = $clog2(NUM_SVC),
  localparam int RING_IDX_W  = $clog2(RING_ENTRIES),
  localparam int ADDR_W      = ((RING_IDX_W > SVC_W + 1) ? RING_IDX_W : SVC_W + 1) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [IP_W-1:0]   inSrcIp,
  input  logic [IP_W-1:0]   inDstIp,
  input  logic [PORT_W-1:0] inSrcPort,
  input  logic [PORT_W-1:0] inDstPort,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [IP_W-1:0]   cfgWrData,
  output logic              outValid,
  input  logic              outReady,
  output logic              outHit,
  output logic [SVC_W-1:0]  outSvc,
  output logic [IP_W-1:0]   outServer
);
  vfsStrobes_t strobes;

  vfsCtrl #(
    .ADDR_W (ADDR_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outReady (outReady),
    .outValid (outValid),
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .strobes  (strobes)
  );

  vfsDatapath #(
    .NUM_SVC      (NUM_SVC),
    .RING_ENTRIES (RING_ENTRIES),
    .ADDR_W       (ADDR_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inSrcIp   (inSrcIp),
    .inDstIp   (inDstIp),
    .inSrcPort (inSrcPort),
    .inDstPort (inDstPort),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .outHit    (outHit),
    .outSvc    (outSvc),
    .outServer (outServer)
  );

  // R9
  held_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outServer) && $stable(outHit) && $stable(outSvc));
endmodule

// File: tb/vipFlowSelector_tb_top.sv
module vipFlowSelector_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inSrcIp = '0, inDstIp = '0;
  logic [15:0] inSrcPort = '0, inDstPort = '0;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        outHit;
  logic [2:0]  outSvc;
  logic [31:0] outServer;

  vipFlowSelector dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inSrcIp(inSrcIp), .inDstIp(inDstIp), .inSrcPort(inSrcPort), .inDstPort(inDstPort),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .outValid(outValid), .outReady(outReady), .outHit(outHit), .outSvc(outSvc),
    .outServer(outServer)
  );

  int checks = 0, fails = 0, cyc = 0;
  int readyMode = 0;   // 0 hold low, 1 hold high, 2 random
  bit latCheckOn = 1'b0;

  logic [31:0] mVip [8];
  bit          mEn  [8];
  int          mBase[8];
  int          mSize[8];
  logic [31:0] mRing[32];

  bit          expHit[1024];
  logic [2:0]  expSvc[1024];
  logic [31:0] expSrv[1024];
  int          expCyc[1024];
  int          wrP = 0, rdP = 0;

  logic [31:0] lastSrv;
  bit          lastHit;
  bit          prevStall = 1'b0;
  logic [31:0] prevSrv;
  bit          prevHit;
  logic [2:0]  prevSvc;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] hashOf(logic [95:0] t);
    logic [4:0] h = '0;
    for (int k = 0; k < 96; k++) h[k % 5] ^= t[k];
    return h;
  endfunction

  function automatic int ringIdxOf(int s, logic [95:0] t);
    int sz = (mSize[s] > 5) ? 5 : mSize[s];
    return (mBase[s] + (int'(hashOf(t)) & ((1 << sz) - 1))) % 32;
  endfunction

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // downstream ready driver
  always @(posedge clk) begin
    #1;
    case (readyMode)
      0: outReady = 1'b0;
      1: outReady = 1'b1;
      default: outReady = ($urandom % 4) != 0;
    endcase
  end

  // monitor, sampling at falling edges
  always @(negedge clk) begin
    if (rstN) begin
      if (inValid && inReady) begin : pushExp
        logic [95:0] t;
        bit h;
        int sv;
        t = {inSrcIp, inDstIp, inSrcPort, inDstPort};
        h = 1'b0; sv = 0;
        for (int s = 7; s >= 0; s--) if (mEn[s] && mVip[s] == inDstIp) begin h = 1'b1; sv = s; end
        expHit[wrP & 1023] = h;
        expSvc[wrP & 1023] = 3'(sv);
        expSrv[wrP & 1023] = h ? mRing[ringIdxOf(sv, t)] : 32'h0;
        expCyc[wrP & 1023] = cyc;
        wrP++;
      end
      if (prevStall) begin
        check(outValid, "R9", 32'(outValid), 32'h1);
        check(outServer == prevSrv && outHit == prevHit && outSvc == prevSvc,
              "R9", outServer, prevSrv);
      end
      prevStall = outValid && !outReady;
      prevSrv = outServer; prevHit = outHit; prevSvc = outSvc;
      if (outValid && outReady) begin
        if (rdP >= wrP) begin
          check(1'b0, "R9", 32'(rdP), 32'(wrP));
        end else begin
          int i;
          i = rdP & 1023;
          check(outHit == expHit[i], "R2 R3", 32'(outHit), 32'(expHit[i]));
          check(outSvc == expSvc[i], "R2 R4", 32'(outSvc), 32'(expSvc[i]));
          if (!expHit[i])        check(outServer == expSrv[i], "R3", outServer, expSrv[i]);
          else if (expSvc[i] == 0) check(outServer == expSrv[i], "R5", outServer, expSrv[i]);
          else                   check(outServer == expSrv[i], "R6 R11", outServer, expSrv[i]);
          if (latCheckOn) check(cyc - expCyc[i] == 2, "R8", 32'(cyc - expCyc[i]), 32'h2);
          rdP++;
        end
        lastSrv = outServer;
        lastHit = outHit;
      end
    end
  end

  // drivers: called just after a rising edge
  task automatic cfgWrite(logic [5:0] a, logic [31:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
  endtask

  task automatic sendTuple(logic [31:0] s, logic [31:0] d, logic [15:0] sp, logic [15:0] dp);
    inValid = 1'b1; inSrcIp = s; inDstIp = d; inSrcPort = sp; inDstPort = dp;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic idleIn();
    inValid = 1'b0;
  endtask

  task automatic drain();
    idleIn();
    while (rdP != wrP) @(posedge clk);
    #1;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendOne(logic [31:0] s, logic [31:0] d, logic [15:0] sp, logic [15:0] dp);
    sendTuple(s, d, sp, dp);
    drain();
  endtask

  initial begin
    logic [31:0] ta;
    int ridx;
    logic [95:0] tt;

    // model configuration
    for (int i = 0; i < 32; i++) mRing[i] = 32'hC0A8_0000 | 32'(i * 37 + 11);
    for (int s = 0; s < 8; s++) begin
      mVip[s]  = 32'h0A00_0100 + 32'(s * 3);
      mEn[s]   = (s != 6);
      mBase[s] = (s * 5 + 3) % 32;
    end
    mBase[0] = 0;
    mVip[7]  = mVip[2];            // duplicate: service 2 must win (R4)
    mSize[0] = 5; mSize[1] = 0; mSize[2] = 2; mSize[3] = 3;
    mSize[4] = 1; mSize[5] = 7; mSize[6] = 2; mSize[7] = 3;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R1", 32'(outValid), 32'h0);
    check(inReady == 1'b1, "R1", 32'(inReady), 32'h1);
    check(outHit == 1'b0 && outSvc == 3'd0, "R1", {28'h0, outHit, outSvc}, 32'h0);
    check(outServer == 32'h0, "R1", outServer, 32'h0);
    @(posedge clk); #1;
    rstN = 1'b1;
    waitCycles(2);
    @(negedge clk);
    check(outValid == 1'b0 && inReady == 1'b1, "R1", {30'h0, outValid, inReady}, 32'h1);
    @(posedge clk); #1;

    // R11: program through the register map
    for (int i = 0; i < 32; i++) cfgWrite(6'(i), mRing[i]);
    for (int s = 0; s < 8; s++) begin
      cfgWrite(6'h20 | 6'(s), mVip[s]);
      cfgWrite(6'h30 | 6'(s), 32'(mBase[s]) | (32'(mSize[s]) << 8) | (mEn[s] ? 32'h8000_0000 : 32'h0));
    end

    // R8: latency and back-to-back throughput
    readyMode = 1;
    waitCycles(3);
    latCheckOn = 1'b1;
    sendOne(32'h6401_0203, mVip[0], 16'd1234, 16'd80);
    for (int n = 0; n < 8; n++) sendTuple($urandom, mVip[n % 8], 16'($urandom), 16'($urandom));
    drain();
    waitCycles(2);
    latCheckOn = 1'b0;

    // sweep over every service plus misses, random backpressure (R2..R6, R9, R11)
    readyMode = 2;
    for (int s = 0; s < 8; s++)
      for (int n = 0; n < 40; n++)
        sendTuple($urandom, mVip[s], 16'($urandom), 16'($urandom));
    for (int n = 0; n < 40; n++)
      sendTuple($urandom, 32'h0B00_0000 | 32'(n), 16'($urandom), 16'($urandom));
    drain();

    // R7: session affinity
    sendOne(32'h6402_0A0B, mVip[3], 16'd40000, 16'd443);
    ta = lastSrv;
    for (int n = 0; n < 20; n++) sendTuple($urandom, mVip[n % 8], 16'($urandom), 16'($urandom));
    drain();
    sendOne(32'h6402_0A0B, mVip[3], 16'd40000, 16'd443);
    check(lastSrv == ta, "R7", lastSrv, ta);

    // R10: writes while a result is parked at the output
    readyMode = 0;
    waitCycles(3);
    tt = {32'h6403_1111, mVip[3], 16'd5555, 16'd53};
    ridx = ringIdxOf(3, tt);
    sendTuple(32'h6403_1111, mVip[3], 16'd5555, 16'd53);
    idleIn();
    waitCycles(4);
    @(negedge clk);
    ta = outServer;
    check(outValid == 1'b1 && ta == mRing[ridx], "R10", ta, mRing[ridx]);
    @(posedge clk); #1;
    cfgWrite(6'(ridx), 32'hDEAD_0000 | 32'(ridx));
    cfgWrite(6'h23, 32'h0A0A_0A0A);
    waitCycles(2);
    @(negedge clk);
    check(outValid == 1'b1 && outServer == ta && outHit == 1'b1, "R10", outServer, ta);
    @(posedge clk); #1;
    readyMode = 1;
    drain();
    mRing[ridx] = 32'hDEAD_0000 | 32'(ridx);
    mVip[3] = 32'h0A0A_0A0A;
    sendOne(32'h6403_1111, 32'h0A00_0109, 16'd5555, 16'd53);   // old address of service 3
    check(lastHit == 1'b0, "R10", 32'(lastHit), 32'h0);
    cfgWrite(6'h23, 32'h0A00_0109);
    mVip[3] = 32'h0A00_0109;
    sendOne(32'h6403_1111, 32'h0A00_0109, 16'd5555, 16'd53);
    check(lastSrv == (32'hDEAD_0000 | 32'(ridx)), "R10", lastSrv, 32'hDEAD_0000 | 32'(ridx));

    waitCycles(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule